// File: doc/BRIEF.md
# Conditional In-Page Branch Unit

This unit resolves the two-byte conditional branch group of a small 4-bit microcontroller. When the sequencer presents an opcode byte, the branch target byte, the address of the first instruction byte and the current flag state, the unit does two things. It decides whether the opcode belongs to the group. It then decides whether the tested condition holds. The tested condition is the carry flag, the zero flag, or one of sixteen user flags.

A taken branch keeps the page bits of the program counter and swaps in the target byte as the low part. The jump therefore never leaves the current 256-word page. A branch that is not taken steps past both instruction bytes, and that step may carry into the page bits. All results are registered. They appear on the outputs one clock after the cycle in which the issue strobe is high. Opcodes outside the group are flagged as not decoded, so that other units keep control of the program counter.

Top module: `brn_unit`

## Requirements
- R1: Opcode 0xDC is decoded and taken exactly when the carry flag is 1.
- R2: Opcode 0x9C is decoded and taken exactly when the carry flag is 0.
- R3: Opcode 0xDD is taken exactly when the zero flag is 1, and opcode 0x9D is taken exactly when the zero flag is 0. Both are decoded.
- R4: An opcode with upper nibble 0xF is decoded. It is taken exactly when user flag n is 1, where n is the opcode's lower nibble and selects bit n of `uflags_i`.
- R5: An opcode with upper nibble 0xB is decoded. It is taken exactly when user flag n is 0, where n is the opcode's lower nibble.
- R6: On a taken branch, `pc_next_o[11:8]` equals `pc_i[11:8]` and `pc_next_o[7:0]` equals `target_i`.
- R7: On a decoded branch that is not taken, `pc_next_o` equals `pc_i + 2` modulo 4096. The addition carries into the page bits.
- R8: An issued opcode outside the six patterns gives `dec_valid_o = 0` and `taken_o = 0`, and leaves `pc_next_o` unchanged.
- R9: Results appear in the cycle after the issue edge. In a cycle after which `issue_i` was low, `dec_valid_o` and `taken_o` are 0 and `pc_next_o` holds its value. `taken_o` is never 1 without `dec_valid_o`.
- R10: During reset, and until the first issue after reset is released, `dec_valid_o = 0`, `taken_o = 0` and `pc_next_o = 0`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_i | input | 1 | An instruction is presented this cycle |
| opcode_i | input | 8 | First instruction byte |
| target_i | input | 8 | Second instruction byte, the in-page target |
| pc_i | input | 12 | Address of the first instruction byte |
| carry_i | input | 1 | Carry flag |
| zero_i | input | 1 | Zero flag |
| uflags_i | input | 16 | User flag register, bit n is flag n |
| dec_valid_o | output | 1 | Opcode was a member of the branch group |
| taken_o | output | 1 | Branch condition held |
| pc_next_o | output | 12 | Next program counter for a decoded branch |

## Verification
Every output is valid one rising edge after the edge that captures `issue_i`. The bench runs a behavioural model that updates on that same capture edge. It compares the outputs with the model at the following falling edge, so each check sees the result of the cycle just issued. The outputs stay at their reset values for two cycles after reset is released, because of the internal synchroniser. The bench keeps `issue_i` low through that window and checks the reset values on every edge of it. Held values are checked on every idle cycle. This covers the hold of `pc_next_o` after idle cycles and after undecoded opcodes.

// File: rtl/brn_pkg.sv
package brn_pkg;

  // Condition source selected by the decoder
  typedef enum logic [1:0] {
    BK_NONE  = 2'd0,
    BK_CARRY = 2'd1,
    BK_ZERO  = 2'd2,
    BK_UFLAG = 2'd3
  } brn_kind_e;

  // Decoded branch: which flag to test and the level that makes it taken
  typedef struct packed {
    brn_kind_e kind;
    logic      want_set;
  } brn_dec_s;

  // Upper-nibble codes of the group; bit 2 of the nibble gives the polarity
  localparam logic [3:0] HI_CORE_SET = 4'hD;
  localparam logic [3:0] HI_CORE_CLR = 4'h9;
  localparam logic [3:0] HI_USR_SET  = 4'hF;
  localparam logic [3:0] HI_USR_CLR  = 4'hB;

  // Lower-nibble codes of the core-flag forms
  localparam logic [3:0] LO_CARRY    = 4'hC;
  localparam logic [3:0] LO_ZERO     = 4'hD;

endpackage

// File: rtl/brn_decode.sv
module brn_decode
  import brn_pkg::*;
#(
  parameter int OP_W  = 8,
  parameter int IDX_W = 4
) (
  input  logic [OP_W-1:0]  opcode,
  output brn_dec_s         dec,
  output logic [IDX_W-1:0] flag_idx
);

  localparam int NIB_W = OP_W / 2;

  logic [NIB_W-1:0] hi_nib;
  logic [NIB_W-1:0] lo_nib;
  logic             core_form;
  logic             user_form;
  logic             pol_set;

  assign hi_nib   = opcode[OP_W-1 -: NIB_W];
  assign lo_nib   = opcode[NIB_W-1:0];
  assign flag_idx = opcode[IDX_W-1:0];

  always_comb begin
    core_form = (hi_nib == NIB_W'(HI_CORE_SET)) || (hi_nib == NIB_W'(HI_CORE_CLR));
    user_form = (hi_nib == NIB_W'(HI_USR_SET))  || (hi_nib == NIB_W'(HI_USR_CLR));
    pol_set   = (hi_nib == NIB_W'(HI_CORE_SET)) || (hi_nib == NIB_W'(HI_USR_SET));
  end

  always_comb begin
    dec.kind     = BK_NONE;
    dec.want_set = pol_set;
    if (user_form) begin
      dec.kind = BK_UFLAG;
    end else if (core_form) begin
      if (lo_nib == NIB_W'(LO_CARRY)) begin
        dec.kind = BK_CARRY;
      end else if (lo_nib == NIB_W'(LO_ZERO)) begin
        dec.kind = BK_ZERO;
      end
    end
  end

endmodule

// File: rtl/brn_cond.sv
module brn_cond
  import brn_pkg::*;
#(
  parameter int NFLAG = 16,
  parameter int IDX_W = 4
) (
  input  brn_dec_s         dec,
  input  logic [IDX_W-1:0] flag_idx,
  input  logic             carry,
  input  logic             zero,
  input  logic [NFLAG-1:0] uflags,
  output logic             decoded,
  output logic             hit
);

  logic [NFLAG-1:0] sel_bits;
  logic             user_lvl;
  logic             test_lvl;

  // One-hot AND-OR selection of the user flag
  for (genvar g = 0; g < NFLAG; g++) begin : g_usel
    assign sel_bits[g] = uflags[g] & (flag_idx == IDX_W'(g));
  end

  assign user_lvl = |sel_bits;

  always_comb begin
    unique case (dec.kind)
      BK_CARRY: test_lvl = carry;
      BK_ZERO:  test_lvl = zero;
      BK_UFLAG: test_lvl = user_lvl;
      default:  test_lvl = 1'b0;
    endcase
  end

  assign decoded = (dec.kind != BK_NONE);
  assign hit     = decoded && (test_lvl == dec.want_set);

endmodule

// File: rtl/brn_pc.sv
module brn_pc #(
  parameter int PC_W  = 12,
  parameter int OFF_W = 8,
  parameter int STEP  = 2
) (
  input  logic [PC_W-1:0]  pc_cur,
  input  logic [OFF_W-1:0] target,
  input  logic             taken,
  output logic [PC_W-1:0]  pc_next
);

  logic [PC_W-1:0] fall_pc;
  logic [PC_W-1:0] jump_pc;

  assign fall_pc = pc_cur + PC_W'(STEP);

  if (PC_W > OFF_W) begin : g_paged
    assign jump_pc = {pc_cur[PC_W-1:OFF_W], target};
  end else begin : g_flat
    assign jump_pc = target[PC_W-1:0];
  end

  assign pc_next = taken ? jump_pc : fall_pc;

endmodule

// File: rtl/brn_unit.sv
module brn_unit
  import brn_pkg::*;
#(
  parameter int PC_W  = 12,
  parameter int OFF_W = 8,
  parameter int OP_W  = 8,
  parameter int NFLAG = 16,
  parameter int STEP  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             issue_i,
  input  logic [OP_W-1:0]  opcode_i,
  input  logic [OFF_W-1:0] target_i,
  input  logic [PC_W-1:0]  pc_i,
  input  logic             carry_i,
  input  logic             zero_i,
  input  logic [NFLAG-1:0] uflags_i,
  output logic             dec_valid_o,
  output logic             taken_o,
  output logic [PC_W-1:0]  pc_next_o
);

  localparam int IDX_W  = $clog2(NFLAG);
  localparam int SYNC_N = 2;

  // Reset: asserted asynchronously, released through a short synchroniser
  logic [SYNC_N-1:0] rst_sync_q;
  logic              rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[SYNC_N-2:0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[SYNC_N-1];

  // Combinational datapath
  brn_dec_s         dec;
  logic [IDX_W-1:0] flag_idx;
  logic             decoded;
  logic             hit;
  logic [PC_W-1:0]  pc_calc;

  brn_decode #(.OP_W(OP_W), .IDX_W(IDX_W)) u_decode (
    .opcode   (opcode_i),
    .dec      (dec),
    .flag_idx (flag_idx)
  );

  brn_cond #(.NFLAG(NFLAG), .IDX_W(IDX_W)) u_cond (
    .dec      (dec),
    .flag_idx (flag_idx),
    .carry    (carry_i),
    .zero     (zero_i),
    .uflags   (uflags_i),
    .decoded  (decoded),
    .hit      (hit)
  );

  brn_pc #(.PC_W(PC_W), .OFF_W(OFF_W), .STEP(STEP)) u_pc (
    .pc_cur   (pc_i),
    .target   (target_i),
    .taken    (hit),
    .pc_next  (pc_calc)
  );

  // Next state
  logic            vld_d;
  logic            taken_d;
  logic            pc_en;
  logic [PC_W-1:0] pc_d;

  always_comb begin
    vld_d   = issue_i && decoded;
    taken_d = issue_i && hit;
    pc_en   = vld_d;
    pc_d    = pc_calc;
  end

  // Registers
  logic            vld_q;
  logic            taken_q;
  logic [PC_W-1:0] pc_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q   <= 1'b0;
      taken_q <= 1'b0;
    end else begin
      vld_q   <= vld_d;
      taken_q <= taken_d;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      pc_q <= '0;
    end else if (pc_en) begin
      pc_q <= pc_d;
    end
  end

  assign dec_valid_o = vld_q;
  assign taken_o     = taken_q;
  assign pc_next_o   = pc_q;

endmodule

// File: rtl/brn_unit_chk.sv
module brn_unit_chk #(
  parameter int PC_W  = 12,
  parameter int OFF_W = 8,
  parameter int OP_W  = 8,
  parameter int NFLAG = 16,
  parameter int STEP  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_i,
  input logic [OP_W-1:0]  opcode_i,
  input logic [OFF_W-1:0] target_i,
  input logic [PC_W-1:0]  pc_i,
  input logic             carry_i,
  input logic             zero_i,
  input logic [NFLAG-1:0] uflags_i,
  input logic             dec_valid_o,
  input logic             taken_o,
  input logic [PC_W-1:0]  pc_next_o
);

  logic in_group;
  assign in_group = (opcode_i == 8'hDC) || (opcode_i == 8'h9C) ||
                    (opcode_i == 8'hDD) || (opcode_i == 8'h9D) ||
                    (opcode_i[7:4] == 4'hF) || (opcode_i[7:4] == 4'hB);

  // R1: carry-set form follows the carry flag
  assert_carry_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && opcode_i == 8'hDC) |=> (dec_valid_o && taken_o == $past(carry_i)));

  // R2: carry-clear form follows the inverted carry flag
  assert_carry_clr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && opcode_i == 8'h9C) |=> (dec_valid_o && taken_o == !$past(carry_i)));

  // R6: a taken branch stays in the page
  assert_in_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && in_group) |=> (!taken_o ||
      pc_next_o == {$past(pc_i[PC_W-1:OFF_W]), $past(target_i)}));

  // R7: fall-through steps over both bytes
  assert_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && in_group) |=> (taken_o || pc_next_o == $past(pc_i) + PC_W'(STEP)));

  // R8: foreign opcodes leave the outputs idle and the PC untouched
  assert_foreign_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !in_group) |=> (!dec_valid_o && !taken_o && $stable(pc_next_o)));

  // R9: nothing is reported after an idle cycle
  assert_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> (!dec_valid_o && !taken_o && $stable(pc_next_o)));

  // R9: taken implies decoded
  assert_taken_vld_R9: assert property (@(posedge clk) disable iff (!rst_n)
    taken_o |-> dec_valid_o);

endmodule

bind brn_unit brn_unit_chk #(
  .PC_W(PC_W), .OFF_W(OFF_W), .OP_W(OP_W), .NFLAG(NFLAG), .STEP(STEP)
) u_brn_unit_chk (
  .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .opcode_i(opcode_i),
  .target_i(target_i), .pc_i(pc_i), .carry_i(carry_i), .zero_i(zero_i),
  .uflags_i(uflags_i), .dec_valid_o(dec_valid_o), .taken_o(taken_o),
  .pc_next_o(pc_next_o)
);

// File: tb/brn_unit_bench.sv
`timescale 1ns/1ps
module brn_unit_bench;

  logic        clk;
  logic        rst_n;
  logic        issue;
  logic [7:0]  opcode;
  logic [7:0]  target;
  logic [11:0] pc;
  logic        carry;
  logic        zero;
  logic [15:0] uflags;
  logic        dec_valid;
  logic        taken;
  logic [11:0] pc_next;

  int  n_checks = 0;
  int  n_fail   = 0;
  bit  chk_on   = 0;
  bit  done     = 0;

  // Model state
  int    e_vld, e_tk, e_pc;
  string tag, ptag;

  brn_unit u_brn_unit (
    .clk(clk), .rst_n(rst_n), .issue_i(issue), .opcode_i(opcode),
    .target_i(target), .pc_i(pc), .carry_i(carry), .zero_i(zero),
    .uflags_i(uflags), .dec_valid_o(dec_valid), .taken_o(taken),
    .pc_next_o(pc_next)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  // Behavioural reference model, advanced on every capture edge
  always @(posedge clk) begin
    int c;
    bit g;
    if (!rst_n) begin
      e_vld = 0; e_tk = 0; e_pc = 0; tag = "R10"; ptag = "R10";
    end else if (issue) begin
      g = 1; c = 0;
      if (opcode == 8'hDC)           begin c = carry;              tag = "R1"; end
      else if (opcode == 8'h9C)      begin c = !carry;             tag = "R2"; end
      else if (opcode == 8'hDD)      begin c = zero;               tag = "R3"; end
      else if (opcode == 8'h9D)      begin c = !zero;              tag = "R3"; end
      else if (opcode[7:4] == 4'hF)  begin c = uflags[opcode[3:0]];  tag = "R4"; end
      else if (opcode[7:4] == 4'hB)  begin c = !uflags[opcode[3:0]]; tag = "R5"; end
      else g = 0;
      if (g) begin
        e_vld = 1; e_tk = c;
        if (c) begin e_pc = (int'(pc) & 'hF00) | int'(target); ptag = "R6"; end
        else   begin e_pc = (int'(pc) + 2) % 4096;             ptag = "R7"; end
      end else begin
        e_vld = 0; e_tk = 0; tag = "R8"; ptag = "R8";
      end
    end else begin
      e_vld = 0; e_tk = 0;
      if (tag != "R10") begin tag = "R9"; ptag = "R9"; end
    end
  end

  // Compare away from the capture edge
  always @(negedge clk) begin
    if (chk_on) begin
      check(int'(dec_valid) == e_vld, tag,  "dec_valid", int'(dec_valid), e_vld);
      check(int'(taken) == e_tk,      tag,  "taken",     int'(taken), e_tk);
      check(int'(pc_next) == e_pc,    ptag, "pc_next",   int'(pc_next), e_pc);
      check(!(taken && !dec_valid), "R9", "taken_without_valid", int'(taken), 0);
    end
  end

  task automatic drive(input logic [7:0] op, input logic [7:0] tg,
                       input logic [11:0] p, input logic c, input logic z,
                       input logic [15:0] uf);
    @(negedge clk);
    issue = 1'b1; opcode = op; target = tg; pc = p;
    carry = c; zero = z; uflags = uf;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    issue = 1'b0;
    opcode = 8'hDC; carry = 1'b1;
    for (int i = 1; i < n; i++) @(negedge clk);
  endtask

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired, run did not complete");
      finish_run();
    end
  end

  initial begin
    logic [7:0] core_ops [4];
    core_ops = '{8'hDC, 8'h9C, 8'hDD, 8'h9D};
    rst_n = 1'b0; issue = 1'b0; opcode = '0; target = '0; pc = '0;
    carry = 1'b0; zero = 1'b0; uflags = '0;
    @(posedge clk); @(posedge clk);
    chk_on = 1;                       // R10: reset state checked from here
    @(negedge clk); rst_n = 1'b1;
    idle(4);                          // R10: values hold through reset release

    // R1, R2, R3: core flag forms, all flag combinations, tag R6/R7 on PC
    for (int k = 0; k < 4; k++)
      for (int f = 0; f < 4; f++)
        drive(core_ops[k], 8'h10, 12'h3A5, f[0], f[1], 16'h0000);
    idle(2);

    // R4, R5: every user flag index with two flag patterns
    for (int n = 0; n < 16; n++) begin
      drive({4'hF, 4'(n)}, 8'(n * 7), 12'h5C0 + 12'(n), 1'b0, 1'b0, 16'hA5C3);
      drive({4'hF, 4'(n)}, 8'(n * 7), 12'h5C0 + 12'(n), 1'b1, 1'b1, 16'h5A3C);
      drive({4'hB, 4'(n)}, 8'(n * 9), 12'h2F0 + 12'(n), 1'b1, 1'b0, 16'hA5C3);
      drive({4'hB, 4'(n)}, 8'(n * 9), 12'h2F0 + 12'(n), 1'b0, 1'b1, 16'h5A3C);
    end
    idle(3);

    // R7: fall-through carrying into the page bits and wrapping
    drive(8'h9C, 8'h44, 12'h0FE, 1'b1, 1'b0, 16'h0);
    drive(8'hDD, 8'h44, 12'h0FF, 1'b0, 1'b0, 16'h0);
    drive(8'hF3, 8'h44, 12'hFFE, 1'b0, 1'b0, 16'h0);
    drive(8'hB3, 8'h44, 12'hFFF, 1'b0, 1'b0, 16'h8);
    // R6: taken at the top of a page stays in that page
    drive(8'hDC, 8'h00, 12'hFFF, 1'b1, 1'b0, 16'h0);
    drive(8'h9D, 8'hFF, 12'h7FE, 1'b0, 1'b0, 16'h0);

    // R8: foreign opcodes interleaved with decoded ones, PC must hold
    for (int op = 0; op < 256; op++) begin
      drive(8'(op), 8'(op ^ 8'h5A), 12'((op * 13) % 4096), op[0], op[1],
            16'(op * 16'h0123));
      if (op % 17 == 0) idle(1);
    end
    idle(4);

    done = 1;
    chk_on = 0;
    finish_run();
  end

endmodule